// File: doc/BRIEF.md
# Descriptor Ring Completion Engine

This block runs one transmit ring and one receive ring of 16-byte descriptors held in a small on-chip descriptor store. Software fills descriptors through a register-style access port, then moves the ring's head index forward to hand them over. For each posted descriptor, in index order, the engine starts a payload handshake. On the transmit side it presents the buffer address, length and frame delimiter codes, and waits for an acknowledge. On the receive side it presents the buffer address and takes the incoming length and delimiter codes with the acknowledge.

When the handshake completes, the engine writes the completion status back into the descriptor itself. On the receive side it also writes the length and delimiter fields. After that write it advances the ring's tail index, and it raises a one-cycle notify pulse if the descriptor asked for an interrupt. The receive side can shape what it reports. Outside raw mode it drops a 4-byte checksum from the length and masks the delimiter codes. In every mode it clips the length to a saturating maximum frame size.

Each descriptor is made of four 32-bit words. Word 0 holds the low address and word 1 the high address. Word 2 is the control word: length in bits 11:0, end-of-frame code in 15:12, start-of-frame code in 19:16 and a 12-bit flag field in 31:20. Word 3 is a time word that software keeps at zero. Within the flag field, bit 0 is isochronous, bit 1 is completed, bit 2 is posted and bit 3 is interrupt request, so those flags sit at control-word bits 20, 21, 22 and 23.

Top module: `desc_ring_engine`

## Requirements
- R1: After reset both rings are disabled, both tails read 0, the count registers read DEPTH, the max-frame register reads 0x100, the mask register reads 0xFF, and tx_req, rx_req, tx_notify and rx_notify are low.
- R2: A ring starts no handshake while it is disabled, or while its tail equals its head.
- R3: Descriptors are processed one at a time in index order. The descriptor at index i lives in store slot (base + i) mod DEPTH, and the tail wraps to 0 when it reaches the count value.
- R4: While tx_req is high, tx_addr, tx_len, tx_eof and tx_sof carry the fields of the descriptor at the tail slot.
- R5: The completion write-back ORs the completed flag (control bit 21) into the control word and keeps all other flag bits. On the transmit ring, length, EOF and SOF stay as software wrote them.
- R6: On receive, the write-back holds the delivered length, EOF and SOF. Outside raw mode, the length is reduced by 4 (floored at 0), EOF is ANDed with mask bits 3:0 and SOF with mask bits 7:4. In raw mode (options bit 30) the length and codes are taken unmasked.
- R7: A max-frame write stores min(value, 0x100). The reported receive length never exceeds the stored max-frame value.
- R8: A notify output pulses high for exactly one cycle per completed descriptor whose interrupt flag (control bit 23) is set, and stays low for descriptors without it.
- R9: Clearing the enable bit (options bit 31) aborts any handshake in flight, drops the request and forces the tail to 0. The pending descriptor is left without its completed flag.
- R10: The completed flag is already in the descriptor store in the first cycle the advanced tail is visible.
- R11: Register map: the address MSB selects the descriptor store (1) or registers (0), and the next bit selects the ring (0 transmit, 1 receive). Register selects are 0 options, 1 base, 2 count, 3 head, 4 tail (read only), 5 max frame (receive), 6 mask (receive). A count write of 0 or above DEPTH stores DEPTH. Options bits 29 to 27 read 0, and the raw bit reads 0 on the transmit ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the access port |
| cfg_addr | input | ADDR_W | {store/reg, ring, index, word} or {0, ring, sel} |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data at cfg_addr |
| tx_req | output | 1 | Transmit payload request |
| tx_addr | output | 64 | Transmit buffer address |
| tx_len | output | 12 | Transmit length |
| tx_eof | output | 4 | Transmit end-of-frame code |
| tx_sof | output | 4 | Transmit start-of-frame code |
| tx_ack | input | 1 | Transmit payload done |
| tx_notify | output | 1 | Transmit completion interrupt pulse |
| rx_req | output | 1 | Receive payload request |
| rx_addr | output | 64 | Receive buffer address |
| rx_ack | input | 1 | Receive payload done, qualifies rx_len/eof/sof |
| rx_len | input | 12 | Delivered receive length |
| rx_eof | input | 4 | Delivered end-of-frame code |
| rx_sof | input | 4 | Delivered start-of-frame code |
| rx_notify | output | 1 | Receive completion interrupt pulse |

## Verification
The hardest state to reach is a ring whose tail wraps while its base offset is not zero. Here the index sequence and the store slot sequence differ, and the head has to be moved behind the tail numerically. The stimulus sets the count to 3 and the base to 5, serves two descriptors, rewrites the slot that will be reused, and then moves the head to 1 so the engine crosses the wrap point. A second hard case is disabling a ring while a handshake is held open. The bench withholds the acknowledge, clears enable, and checks that the request drops, the tail returns to 0 and the descriptor stays uncompleted.

// File: rtl/dre_pkg.sv
package dre_pkg;
  // flag positions inside the 12-bit flag field
  localparam int FLG_ISO  = 0;
  localparam int FLG_DONE = 1;
  localparam int FLG_POST = 2;
  localparam int FLG_IRQ  = 3;
  localparam int CTRL_FLAG_LSB = 20;

  // option word bits
  localparam int OPT_EN  = 31;
  localparam int OPT_RAW = 30;

  // register selects
  localparam logic [2:0] REG_OPT  = 3'd0;
  localparam logic [2:0] REG_BASE = 3'd1;
  localparam logic [2:0] REG_CNT  = 3'd2;
  localparam logic [2:0] REG_HEAD = 3'd3;
  localparam logic [2:0] REG_TAIL = 3'd4;
  localparam logic [2:0] REG_MAXF = 3'd5;
  localparam logic [2:0] REG_MASK = 3'd6;

  localparam int MAXF_CAP = 256;
  localparam int CSUM_BYTES = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_WB, ST_ADV} eng_st_e;
endpackage

// File: rtl/dre_desc_store.sv
module dre_desc_store #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LOC_W = IDX_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic [1:0]       sw_word,
  input  logic [31:0]      sw_wdata,
  output logic [31:0]      sw_rdata,
  input  logic [IDX_W-1:0] eng_idx,
  input  logic             eng_we,
  input  logic [31:0]      eng_wdata,
  output logic [63:0]      eng_addr,
  output logic [31:0]      eng_ctrl
);
  logic [31:0] mem_q [DEPTH*4];
  logic [LOC_W-1:0] sw_loc, eng_loc;
  logic sw_blocked;

  always_comb begin
    sw_loc     = {sw_idx, sw_word};
    eng_loc    = {eng_idx, 2'd2};
    sw_blocked = eng_we && (sw_loc == eng_loc);
  end

  // engine write-back takes precedence over a colliding software write
  always_ff @(posedge clk) begin
    if (eng_we) mem_q[eng_loc] <= eng_wdata;
    if (sw_we && !sw_blocked) mem_q[sw_loc] <= sw_wdata;
  end

  assign sw_rdata = mem_q[sw_loc];
  assign eng_addr = {mem_q[{eng_idx, 2'd1}], mem_q[{eng_idx, 2'd0}]};
  assign eng_ctrl = mem_q[eng_loc];

  // R5/R10: write-back data is in the store on the next cycle
  p_wb_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |=> (mem_q[$past(eng_loc)] == $past(eng_wdata)));
endmodule

// File: rtl/dre_ring_engine.sv
module dre_ring_engine import dre_pkg::*; #(
  parameter int DEPTH   = 8,
  parameter bit HW_FILL = 1'b0,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic [IDX_W-1:0] slot,
  input  logic [31:0]      desc_ctrl,
  input  logic [19:0]      fill_in,
  output logic             xfer_req,
  input  logic             xfer_ack,
  output logic             wb_we,
  output logic [31:0]      wb_data,
  output logic             notify
);
  eng_st_e          st_q, st_d;
  logic             en_q, en_d;
  logic [IDX_W-1:0] base_q, base_d, head_q, head_d, tail_q, tail_d;
  logic [IDX_W:0]   cnt_q, cnt_d;
  logic [31:0]      cur_q, cur_d;
  logic [19:0]      fill_q, fill_d;
  logic             ntf_q, ntf_d;
  logic [IDX_W:0]   tail_inc;
  logic [11:0]      flags_wb;

  // next-state
  always_comb begin
    st_d   = st_q;
    en_d   = en_q;
    base_d = base_q;
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    cur_d  = cur_q;
    fill_d = fill_q;
    ntf_d  = 1'b0;
    tail_inc = {1'b0, tail_q} + 1'b1;

    if (reg_we) begin
      case (reg_sel)
        REG_OPT:  en_d   = reg_wdata[OPT_EN];
        REG_BASE: base_d = reg_wdata[IDX_W-1:0];
        REG_HEAD: head_d = reg_wdata[IDX_W-1:0];
        REG_CNT: begin
          if (reg_wdata == 32'd0 || reg_wdata > 32'(DEPTH)) cnt_d = (IDX_W+1)'(DEPTH);
          else cnt_d = reg_wdata[IDX_W:0];
        end
        default: ;
      endcase
    end

    if (!en_q) begin
      st_d   = ST_IDLE;
      tail_d = '0;
    end else begin
      case (st_q)
        ST_IDLE: if (tail_q != head_q) begin
          cur_d = desc_ctrl;
          st_d  = ST_XFER;
        end
        ST_XFER: if (xfer_ack) begin
          fill_d = fill_in;
          st_d   = ST_WB;
        end
        ST_WB: st_d = ST_ADV;
        ST_ADV: begin
          tail_d = (tail_inc == cnt_q) ? '0 : tail_inc[IDX_W-1:0];
          ntf_d  = cur_q[CTRL_FLAG_LSB+FLG_IRQ];
          st_d   = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      en_q   <= 1'b0;
      base_q <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= (IDX_W+1)'(DEPTH);
      cur_q  <= '0;
      fill_q <= '0;
      ntf_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      en_q   <= en_d;
      base_q <= base_d;
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
      cur_q  <= cur_d;
      fill_q <= fill_d;
      ntf_q  <= ntf_d;
    end
  end

  always_comb begin
    flags_wb = cur_q[31:CTRL_FLAG_LSB] | 12'(1 << FLG_DONE);
    slot     = base_q + tail_q;
    xfer_req = en_q && (st_q == ST_XFER);
    wb_we    = en_q && (st_q == ST_WB);
    wb_data  = {flags_wb, HW_FILL ? fill_q : cur_q[19:0]};
    notify   = ntf_q;
    case (reg_sel)
      REG_OPT:  reg_rdata = {en_q, 31'b0};
      REG_BASE: reg_rdata = 32'(base_q);
      REG_CNT:  reg_rdata = 32'(cnt_q);
      REG_HEAD: reg_rdata = 32'(head_q);
      REG_TAIL: reg_rdata = 32'(tail_q);
      default:  reg_rdata = 32'd0;
    endcase
  end

  p_tail_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (tail_q == '0));
  p_notify_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    notify |=> !notify);
  p_notify_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    notify |-> ($past(st_q) == ST_ADV));
  p_tail_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_q != $past(tail_q)) |-> (($past(st_q) == ST_ADV) || !$past(en_q)));
  p_wb_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADV) |-> $past(wb_we));
endmodule

// File: rtl/dre_rx_shape.sv
module dre_rx_shape import dre_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [11:0] in_len,
  input  logic [3:0]  in_eof,
  input  logic [3:0]  in_sof,
  output logic [11:0] out_len,
  output logic [3:0]  out_eof,
  output logic [3:0]  out_sof
);
  logic       raw_q, raw_d;
  logic [8:0] lim_q, lim_d;
  logic [7:0] msk_q, msk_d;
  logic [11:0] adj_len;

  always_comb begin
    raw_d = raw_q;
    lim_d = lim_q;
    msk_d = msk_q;
    if (reg_we) begin
      case (reg_sel)
        REG_OPT:  raw_d = reg_wdata[OPT_RAW];
        REG_MAXF: lim_d = (reg_wdata > 32'(MAXF_CAP)) ? 9'(MAXF_CAP) : reg_wdata[8:0];
        REG_MASK: msk_d = reg_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      lim_q <= 9'(MAXF_CAP);
      msk_q <= 8'hFF;
    end else begin
      raw_q <= raw_d;
      lim_q <= lim_d;
      msk_q <= msk_d;
    end
  end

  always_comb begin
    if (raw_q) adj_len = in_len;
    else if (in_len >= 12'(CSUM_BYTES)) adj_len = in_len - 12'(CSUM_BYTES);
    else adj_len = '0;
    out_len = (adj_len > {3'b0, lim_q}) ? {3'b0, lim_q} : adj_len;
    out_eof = raw_q ? in_eof : (in_eof & msk_q[3:0]);
    out_sof = raw_q ? in_sof : (in_sof & msk_q[7:4]);
    case (reg_sel)
      REG_OPT:  reg_rdata = {1'b0, raw_q, 30'b0};
      REG_MAXF: reg_rdata = 32'(lim_q);
      REG_MASK: reg_rdata = 32'(msk_q);
      default:  reg_rdata = 32'd0;
    endcase
  end

  p_len_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_len <= 12'(MAXF_CAP));
  p_lim_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lim_q <= 9'(MAXF_CAP));
endmodule

// File: rtl/desc_ring_engine.sv
module desc_ring_engine #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int ADDR_W = IDX_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              tx_req,
  output logic [63:0]       tx_addr,
  output logic [11:0]       tx_len,
  output logic [3:0]        tx_eof,
  output logic [3:0]        tx_sof,
  input  logic              tx_ack,
  output logic              tx_notify,
  output logic              rx_req,
  output logic [63:0]       rx_addr,
  input  logic              rx_ack,
  input  logic [11:0]       rx_len,
  input  logic [3:0]        rx_eof,
  input  logic [3:0]        rx_sof,
  output logic              rx_notify
);
  logic             is_desc, ring_rx;
  logic [IDX_W-1:0] a_idx;
  logic [1:0]       a_word;
  logic [2:0]       a_sel;
  logic             tx_sw_we, rx_sw_we, tx_reg_we, rx_reg_we;
  logic [31:0]      tx_sw_rd, rx_sw_rd, tx_reg_rd, rx_reg_rd, shp_reg_rd;
  logic [IDX_W-1:0] tx_slot, rx_slot;
  logic [31:0]      tx_ctrl, rx_ctrl, tx_wb, rx_wb;
  logic             tx_wb_we, rx_wb_we;
  logic [11:0]      shp_len;
  logic [3:0]       shp_eof, shp_sof;

  always_comb begin
    is_desc   = cfg_addr[ADDR_W-1];
    ring_rx   = cfg_addr[ADDR_W-2];
    a_idx     = cfg_addr[IDX_W+1:2];
    a_word    = cfg_addr[1:0];
    a_sel     = cfg_addr[2:0];
    tx_sw_we  = cfg_wr && is_desc && !ring_rx;
    rx_sw_we  = cfg_wr && is_desc && ring_rx;
    tx_reg_we = cfg_wr && !is_desc && !ring_rx;
    rx_reg_we = cfg_wr && !is_desc && ring_rx;
    if (is_desc) cfg_rdata = ring_rx ? rx_sw_rd : tx_sw_rd;
    else         cfg_rdata = ring_rx ? (rx_reg_rd | shp_reg_rd) : tx_reg_rd;
  end

  dre_desc_store #(.DEPTH(DEPTH)) u_tx_store (
    .clk(clk), .rst_n(rst_n),
    .sw_we(tx_sw_we), .sw_idx(a_idx), .sw_word(a_word), .sw_wdata(cfg_wdata), .sw_rdata(tx_sw_rd),
    .eng_idx(tx_slot), .eng_we(tx_wb_we), .eng_wdata(tx_wb), .eng_addr(tx_addr), .eng_ctrl(tx_ctrl)
  );

  dre_desc_store #(.DEPTH(DEPTH)) u_rx_store (
    .clk(clk), .rst_n(rst_n),
    .sw_we(rx_sw_we), .sw_idx(a_idx), .sw_word(a_word), .sw_wdata(cfg_wdata), .sw_rdata(rx_sw_rd),
    .eng_idx(rx_slot), .eng_we(rx_wb_we), .eng_wdata(rx_wb), .eng_addr(rx_addr), .eng_ctrl(rx_ctrl)
  );

  dre_ring_engine #(.DEPTH(DEPTH), .HW_FILL(1'b0)) u_tx_eng (
    .clk(clk), .rst_n(rst_n),
    .reg_we(tx_reg_we), .reg_sel(a_sel), .reg_wdata(cfg_wdata), .reg_rdata(tx_reg_rd),
    .slot(tx_slot), .desc_ctrl(tx_ctrl), .fill_in(20'd0),
    .xfer_req(tx_req), .xfer_ack(tx_ack), .wb_we(tx_wb_we), .wb_data(tx_wb), .notify(tx_notify)
  );

  dre_rx_shape u_rx_shape (
    .clk(clk), .rst_n(rst_n),
    .reg_we(rx_reg_we), .reg_sel(a_sel), .reg_wdata(cfg_wdata), .reg_rdata(shp_reg_rd),
    .in_len(rx_len), .in_eof(rx_eof), .in_sof(rx_sof),
    .out_len(shp_len), .out_eof(shp_eof), .out_sof(shp_sof)
  );

  dre_ring_engine #(.DEPTH(DEPTH), .HW_FILL(1'b1)) u_rx_eng (
    .clk(clk), .rst_n(rst_n),
    .reg_we(rx_reg_we), .reg_sel(a_sel), .reg_wdata(cfg_wdata), .reg_rdata(rx_reg_rd),
    .slot(rx_slot), .desc_ctrl(rx_ctrl), .fill_in({shp_sof, shp_eof, shp_len}),
    .xfer_req(rx_req), .xfer_ack(rx_ack), .wb_we(rx_wb_we), .wb_data(rx_wb), .notify(rx_notify)
  );

  assign tx_len = tx_ctrl[11:0];
  assign tx_eof = tx_ctrl[15:12];
  assign tx_sof = tx_ctrl[19:16];
endmodule

// File: tb/tb_desc_ring_engine.sv
module tb_desc_ring_engine;
  localparam int DEPTH = 8;
  localparam int AW = 7;
  localparam logic [31:0] F_ISO = 32'h0010_0000;
  localparam logic [31:0] F_DONE = 32'h0020_0000;
  localparam logic [31:0] F_POST = 32'h0040_0000;
  localparam logic [31:0] F_IRQ = 32'h0080_0000;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr;
  logic [AW-1:0] cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic tx_req, tx_ack, tx_notify, rx_req, rx_ack, rx_notify;
  logic [63:0] tx_addr, rx_addr;
  logic [11:0] tx_len, rx_len;
  logic [3:0] tx_eof, tx_sof, rx_eof, rx_sof;

  int n_cmp = 0;
  int n_bad = 0;
  int tx_ntf = 0;
  int rx_ntf = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  desc_ring_engine #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tx_req(tx_req), .tx_addr(tx_addr), .tx_len(tx_len), .tx_eof(tx_eof),
    .tx_sof(tx_sof), .tx_ack(tx_ack), .tx_notify(tx_notify), .rx_req(rx_req), .rx_addr(rx_addr),
    .rx_ack(rx_ack), .rx_len(rx_len), .rx_eof(rx_eof), .rx_sof(rx_sof), .rx_notify(rx_notify)
  );

  always @(negedge clk) begin
    if (tx_notify === 1'b1) tx_ntf++;
    if (rx_notify === 1'b1) rx_ntf++;
  end

  function automatic logic [AW-1:0] da(input bit rx, input int slot, input int word);
    return {1'b1, rx, slot[2:0], word[1:0]};
  endfunction
  function automatic logic [AW-1:0] ra(input bit rx, input int sel);
    return {1'b0, rx, 2'b00, sel[2:0]};
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic put_desc(input bit rx, input int slot, input logic [63:0] ba, input logic [31:0] ctrl);
    wr(da(rx, slot, 0), ba[31:0]);
    wr(da(rx, slot, 1), ba[63:32]);
    wr(da(rx, slot, 2), ctrl);
    wr(da(rx, slot, 3), 32'd0);
  endtask

  task automatic wait_req(input bit rx);
    for (int i = 0; i < 100; i++) begin
      if ((rx ? rx_req : tx_req) === 1'b1) break;
      @(negedge clk);
    end
  endtask

  // serve one transmit descriptor and check the write-back
  task automatic serve_tx(input int slot, input logic [63:0] ba, input logic [31:0] ctrl, input int exp_tail);
    logic [31:0] d;
    logic irq;
    irq = ctrl[23];
    wait_req(1'b0);
    chk("R4 tx_req", tx_req, 1);
    chk("R4 tx_addr", tx_addr, ba);
    chk("R4 tx_len/eof/sof", {tx_sof, tx_eof, tx_len}, ctrl[19:0]);
    tx_ack = 1'b1;
    @(negedge clk);
    tx_ack = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 tx_notify", tx_notify, irq);
    rd(ra(0, 4), d);
    chk("R3 tx tail", d, exp_tail);
    rd(da(0, slot, 2), d);
    chk("R5/R10 tx write-back", d, ctrl | F_DONE);
  endtask

  task automatic serve_rx(input int slot, input logic [11:0] l, input logic [3:0] e, input logic [3:0] s,
                          input logic [31:0] exp_ctrl, input int exp_tail);
    logic [31:0] d;
    wait_req(1'b1);
    chk("R2 rx_req", rx_req, 1);
    rx_ack = 1'b1; rx_len = l; rx_eof = e; rx_sof = s;
    @(negedge clk);
    rx_ack = 1'b0; rx_len = '0; rx_eof = '0; rx_sof = '0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 rx_notify", rx_notify, exp_ctrl[23]);
    rd(ra(1, 4), d);
    chk("R3 rx tail", d, exp_tail);
    rd(da(1, slot, 2), d);
    chk("R6 rx write-back", d, exp_ctrl);
  endtask

  task automatic idle_check(input bit rx, input string rq);
    int seen;
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if ((rx ? rx_req : tx_req) !== 1'b0) seen++;
    end
    chk(rq, seen, 0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 tx_req", tx_req, 0);
    chk("R1 rx_req", rx_req, 0);
    chk("R1 notifies", {tx_notify, rx_notify}, 0);
    rd(ra(0, 4), d); chk("R1 tx tail", d, 0);
    rd(ra(1, 4), d); chk("R1 rx tail", d, 0);
    rd(ra(0, 0), d); chk("R1 tx options", d, 0);
    rd(ra(1, 2), d); chk("R1 rx count", d, DEPTH);
    rd(ra(1, 5), d); chk("R1 max frame", d, 32'h100);
    rd(ra(1, 6), d); chk("R1 mask", d, 32'hFF);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(ra(0, 2), 0);   rd(ra(0, 2), d); chk("R11 count zero", d, DEPTH);
    wr(ra(0, 2), 100); rd(ra(0, 2), d); chk("R11 count large", d, DEPTH);
    wr(ra(0, 2), 3);   rd(ra(0, 2), d); chk("R11 count 3", d, 3);
    wr(ra(0, 0), 32'hFFFF_FFFF); rd(ra(0, 0), d); chk("R11 tx options", d, 32'h8000_0000);
    wr(ra(1, 0), 32'hFFFF_FFFF); rd(ra(1, 0), d); chk("R11 rx options", d, 32'hC000_0000);
    wr(ra(1, 5), 32'h1000); rd(ra(1, 5), d); chk("R7 max frame sat", d, 32'h100);
    wr(ra(1, 5), 32'h40);   rd(ra(1, 5), d); chk("R7 max frame", d, 32'h40);
    wr(ra(0, 0), 0); wr(ra(1, 0), 0);
    wr(ra(0, 2), DEPTH); wr(ra(1, 5), 32'h100);
  endtask

  task automatic t_tx_basic;
    logic [31:0] c0, c1, c2;
    int n0;
    c0 = F_POST | F_ISO | {12'd0, 4'h2, 4'h1, 12'd64};
    c1 = F_POST | F_IRQ | {12'd0, 4'h3, 4'h7, 12'd200};
    c2 = F_POST | {12'd0, 4'hA, 4'h5, 12'd9};
    put_desc(0, 0, 64'h1111_0000_0000_1000, c0);
    put_desc(0, 1, 64'h2222_0000_0000_2000, c1);
    put_desc(0, 2, 64'h3333_0000_0000_3000, c2);
    wr(ra(0, 3), 0);
    wr(ra(0, 0), 32'h8000_0000);
    idle_check(0, "R2 empty ring stalls");
    n0 = tx_ntf;
    wr(ra(0, 3), 3);
    serve_tx(0, 64'h1111_0000_0000_1000, c0, 1);
    serve_tx(1, 64'h2222_0000_0000_2000, c1, 2);
    serve_tx(2, 64'h3333_0000_0000_3000, c2, 3);
    idle_check(0, "R2 caught-up ring stalls");
    chk("R8 one-cycle tx pulse count", tx_ntf - n0, 1);
  endtask

  task automatic t_wrap;
    logic [31:0] c;
    c = F_POST | {12'd0, 4'h1, 4'h1, 12'd16};
    wr(ra(0, 0), 0);
    wr(ra(0, 3), 0);
    wr(ra(0, 2), 3);
    wr(ra(0, 1), 5);
    put_desc(0, 5, 64'h50, c);
    put_desc(0, 6, 64'h60, c);
    put_desc(0, 7, 64'h70, c | F_IRQ);
    wr(ra(0, 0), 32'h8000_0000);
    wr(ra(0, 3), 2);
    serve_tx(5, 64'h50, c, 1);
    serve_tx(6, 64'h60, c, 2);
    put_desc(0, 5, 64'h55, c);
    wr(ra(0, 3), 1);
    serve_tx(7, 64'h70, c | F_IRQ, 0);
    serve_tx(5, 64'h55, c, 1);
    idle_check(0, "R3 wrapped ring stops at head");
  endtask

  task automatic t_disable;
    logic [31:0] d;
    int n0;
    wr(ra(0, 0), 0);
    wr(ra(0, 1), 0);
    wr(ra(0, 2), DEPTH);
    wr(ra(0, 3), 0);
    put_desc(0, 0, 64'hAB, F_POST | F_IRQ);
    wr(ra(0, 0), 32'h8000_0000);
    wr(ra(0, 3), 1);
    wait_req(0);
    chk("R9 request before disable", tx_req, 1);
    n0 = tx_ntf;
    wr(ra(0, 0), 0);
    chk("R9 request dropped", tx_req, 0);
    @(negedge clk);
    rd(ra(0, 4), d); chk("R9 tail forced 0", d, 0);
    rd(da(0, 0, 2), d); chk("R9 not completed", d, F_POST | F_IRQ);
    idle_check(0, "R2 disabled ring stalls");
    chk("R9 no notify", tx_ntf - n0, 0);
  endtask

  task automatic t_rx;
    int n0;
    wr(ra(1, 6), 32'hC5);
    wr(ra(1, 3), 0);
    put_desc(1, 0, 64'h9000, F_POST | F_IRQ);
    put_desc(1, 1, 64'h9100, F_POST);
    wr(ra(1, 0), 32'h8000_0000);
    n0 = rx_ntf;
    wr(ra(1, 3), 2);
    wait_req(1);
    chk("R3 rx_addr", rx_addr, 64'h9000);
    serve_rx(0, 12'd100, 4'hF, 4'hF, F_POST | F_IRQ | F_DONE | {12'd0, 4'hC, 4'h5, 12'd96}, 1);
    serve_rx(1, 12'd2, 4'h3, 4'h3, F_POST | F_DONE | {12'd0, 4'h0, 4'h1, 12'd0}, 2);
    chk("R8 one-cycle rx pulse count", rx_ntf - n0, 1);
  endtask

  task automatic t_rx_raw;
    wr(ra(1, 5), 32'h40);
    put_desc(1, 2, 64'h9200, F_POST);
    put_desc(1, 3, 64'h9300, F_POST);
    wr(ra(1, 0), 32'hC000_0000);
    wr(ra(1, 3), 3);
    serve_rx(2, 12'h80, 4'h3, 4'h9, F_POST | F_DONE | {12'd0, 4'h9, 4'h3, 12'h40}, 3);
    wr(ra(1, 0), 32'h8000_0000);
    wr(ra(1, 3), 4);
    serve_rx(3, 12'h50, 4'hF, 4'hA, F_POST | F_DONE | {12'd0, 4'h8, 4'h5, 12'h40}, 4);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    tx_ack = 1'b0; rx_ack = 1'b0; rx_len = '0; rx_eof = '0; rx_sof = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_tx_basic();
    t_wrap();
    t_disable();
    t_rx();
    t_rx_raw();
    done = 1'b1;
    finish_run();
  end
endmodule